// File: doc/BRIEF.md
# Data-Memory Address Generator with Bit-Reversed Walk

The block forms one 16-bit data-memory address every cycle. It holds a single 16-bit address register (AR) and has an internal 10-bit walk counter. The address comes from the AR, a 16-bit operand from the register file and a 10-bit signed immediate, as chosen by a 4-bit operation code. The address output, the access strobe and the AR value are combinational from the current state and inputs. All state updates happen on the rising clock edge.

There are plain offset modes, scaled offset modes and post-modify modes that write the computed address back into the AR. A bit-reversed mode steps through one 1024-word buffer. That buffer must start on a 1024-word boundary, and its base is loaded into the AR. Each bit-reversed cycle emits the AR's upper six bits followed by the bit reversal of the walk counter, then advances the counter. A run of 1024 consecutive bit-reversed cycles therefore touches every word of the buffer exactly once.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset the AR holds 0 and the walk counter holds 0, so the first bit-reversed access after reset has low ten address bits equal to 0.
- R2: Code 0 (idle) and the unused codes 11 to 15 drive the address output equal to the AR and the access strobe low. They leave the AR and the walk counter unchanged.
- R3: Code 1 outputs the register-file operand plus the sign-extended immediate, with the strobe high. The AR is unchanged.
- R4: Code 2 outputs the AR plus the register-file operand, with the strobe high. The AR is unchanged.
- R5: Code 3 writes the register-file operand into the AR at the clock edge and clears the walk counter. During that cycle the address equals the old AR and the strobe is low.
- R6: Codes 4, 5 and 6 output the AR plus the sign-extended immediate shifted left by 0, 1 and 2 bits respectively, with the strobe high. The AR is unchanged.
- R7: Codes 7, 8 and 9 output the AR plus the sign-extended immediate shifted left by 0, 1 and 2 bits respectively, with the strobe high. At the clock edge the AR takes that same address.
- R8: Code 10 outputs AR[15:10] in address bits 15:10 and the bit-reversed walk counter in bits 9:0, with the strobe high. The AR is unchanged.
- R9: The walk counter advances by one on every code-10 cycle only and wraps from 1023 to 0. So 1024 consecutive code-10 cycles after an AR load cover all 1024 words of the aligned buffer, and the next one returns to the base.
- R10: All sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code (0 to 10 defined, others idle) |
| rf_i | input | 16 | Operand from the register file |
| imm_i | input | 10 | Signed immediate from the instruction |
| addr_o | output | 16 | Data-memory address |
| mem_en_o | output | 1 | Memory access strobe |
| ar_o | output | 16 | Current address register value |

## Verification
A wrong AR value appears on ar_o in the cycle right after the faulty edge. It also corrupts the very next AR-based address, so a per-cycle comparison against a behavioural model catches a bad load or post-modify write within one cycle. A wrong walk counter is hidden until the next bit-reversed cycle, where it shows in the low ten address bits. To expose it, walks are interrupted by idle cycles and reloads, and a full 1024-cycle walk is followed by a coverage check that every buffer word was emitted exactly once.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_RF_IMM = 4'd1,
    OP_AR_RF  = 4'd2,
    OP_LOAD   = 4'd3,
    OP_OFS1   = 4'd4,
    OP_OFS2   = 4'd5,
    OP_OFS4   = 4'd6,
    OP_PM1    = 4'd7,
    OP_PM2    = 4'd8,
    OP_PM4    = 4'd9,
    OP_BREV   = 4'd10
  } agu_op_e;

  typedef struct packed {
    logic       base_rf;   // sum base: 1 = register file, 0 = AR
    logic       add_rf;    // sum addend: 1 = register file, 0 = scaled immediate
    logic [1:0] shift;     // immediate left shift
    logic       use_sum;   // address comes from the adder
    logic       ar_post;   // AR takes the sum
    logic       ar_load;   // AR takes the register-file operand
    logic       brev;      // bit-reversed walk cycle
    logic       mem_en;    // memory access strobe
  } agu_ctrl_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [3:0] op_i,
  output agu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (op_i)
      OP_RF_IMM: begin
        ctrl_o.base_rf = 1'b1;
        ctrl_o.use_sum = 1'b1;
        ctrl_o.mem_en  = 1'b1;
      end
      OP_AR_RF: begin
        ctrl_o.add_rf  = 1'b1;
        ctrl_o.use_sum = 1'b1;
        ctrl_o.mem_en  = 1'b1;
      end
      OP_LOAD: ctrl_o.ar_load = 1'b1;
      OP_OFS1, OP_OFS2, OP_OFS4: begin
        ctrl_o.shift   = 2'(op_i - OP_OFS1);
        ctrl_o.use_sum = 1'b1;
        ctrl_o.mem_en  = 1'b1;
      end
      OP_PM1, OP_PM2, OP_PM4: begin
        ctrl_o.shift   = 2'(op_i - OP_PM1);
        ctrl_o.use_sum = 1'b1;
        ctrl_o.ar_post = 1'b1;
        ctrl_o.mem_en  = 1'b1;
      end
      OP_BREV: begin
        ctrl_o.brev   = 1'b1;
        ctrl_o.mem_en = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/agu_imm_scale.sv
module agu_imm_scale #(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input  logic [IW-1:0] imm_i,
  input  logic [1:0]    shift_i,
  output logic [AW-1:0] ofs_o
);

  localparam int EXT = AW - IW;

  function automatic logic [AW-1:0] sext(input logic [IW-1:0] v);
    return {{EXT{v[IW-1]}}, v};
  endfunction

  assign ofs_o = sext(imm_i) << shift_i;

endmodule

// File: rtl/agu_rev_counter.sv
module agu_rev_counter #(
  parameter int RW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [RW-1:0] rev_o
);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i) cnt_q <= '0;
    else if (step_i)        cnt_q <= cnt_q + 1'b1;
  end

  for (genvar b = 0; b < RW; b++) begin : g_rev
    assign rev_o[b] = cnt_q[RW-1-b];
  end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 10,
  parameter int RW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] rf_i,
  input  logic [IW-1:0] imm_i,
  output logic [AW-1:0] addr_o,
  output logic          mem_en_o,
  output logic [AW-1:0] ar_o
);

  localparam int PAGE_W = AW - RW;

  agu_ctrl_t     ctrl;
  logic [AW-1:0] ar_q;
  logic [AW-1:0] imm_ofs;
  logic [AW-1:0] base;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;
  logic [RW-1:0] rev_idx;

  // named events for the checker
  logic ar_load_evt;
  logic ar_post_evt;
  logic brev_evt;

  function automatic logic [AW-1:0] add_wrap(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction

  agu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  agu_imm_scale #(.AW(AW), .IW(IW)) u_scale (
    .imm_i   (imm_i),
    .shift_i (ctrl.shift),
    .ofs_o   (imm_ofs)
  );

  assign ar_load_evt = ctrl.ar_load;
  assign ar_post_evt = ctrl.ar_post;
  assign brev_evt    = ctrl.brev;

  agu_rev_counter #(.RW(RW)) u_rev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (ar_load_evt),
    .step_i  (brev_evt),
    .rev_o   (rev_idx)
  );

  assign base   = ctrl.base_rf ? rf_i : ar_q;
  assign addend = ctrl.add_rf  ? rf_i : imm_ofs;
  assign sum    = add_wrap(base, addend);

  always_comb begin
    if (brev_evt)          addr_o = {ar_q[AW-1 -: PAGE_W], rev_idx};
    else if (ctrl.use_sum) addr_o = sum;
    else                   addr_o = ar_q;
  end

  assign mem_en_o = ctrl.mem_en;
  assign ar_o     = ar_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)          ar_q <= '0;
    else if (ar_load_evt) ar_q <= rf_i;
    else if (ar_post_evt) ar_q <= sum;
  end

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 16,
  parameter int RW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    op_i,
  input logic [AW-1:0] rf_i,
  input logic [AW-1:0] addr_o,
  input logic          mem_en_o,
  input logic [AW-1:0] ar_o,
  input logic          brev_evt,
  input logic          ar_load_evt
);

  logic          idle_op;
  logic          post_op;
  logic          prev_brev;
  logic [RW-1:0] prev_low;

  assign idle_op = (op_i == 4'd0) || (op_i > 4'd10);
  assign post_op = (op_i >= 4'd7) && (op_i <= 4'd9);

  function automatic logic [RW-1:0] rev(input logic [RW-1:0] v);
    logic [RW-1:0] r;
    for (int i = 0; i < RW; i++) r[i] = v[RW-1-i];
    return r;
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_brev <= 1'b0;
      prev_low  <= '0;
    end else begin
      prev_brev <= (op_i == 4'd10);
      prev_low  <= addr_o[RW-1:0];
    end
  end

  p_idle_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_op |-> (addr_o == ar_o) && !mem_en_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_op |=> $stable(ar_o));

  p_load_ar_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd3) |=> (ar_o == $past(rf_i)));

  p_post_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_op |=> (ar_o == $past(addr_o)));

  p_brev_page_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |-> (addr_o[AW-1:RW] == ar_o[AW-1:RW]) && mem_en_o && brev_evt && !ar_load_evt);

  p_brev_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_brev && op_i == 4'd10) |-> (rev(addr_o[RW-1:0]) == RW'(rev(prev_low) + 1'b1)));

endmodule

bind addr_gen_unit agu_checker #(.AW(AW), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .rf_i        (rf_i),
  .addr_o      (addr_o),
  .mem_en_o    (mem_en_o),
  .ar_o        (ar_o),
  .brev_evt    (brev_evt),
  .ar_load_evt (ar_load_evt)
);

// File: tb/addr_gen_unit_test.sv
module addr_gen_unit_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] rf_i = 16'd0;
  logic [9:0]  imm_i = 10'd0;
  logic [15:0] addr_o;
  logic        mem_en_o;
  logic [15:0] ar_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int m_ar  = 0;
  int m_cnt = 0;
  bit seen [1024];

  always #10 clk_i = ~clk_i;

  addr_gen_unit uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .rf_i     (rf_i),
    .imm_i    (imm_i),
    .addr_o   (addr_o),
    .mem_en_o (mem_en_o),
    .ar_o     (ar_o)
  );

  function automatic string req_of(int op);
    if (op == 0 || op > 10) return "R2";
    if (op == 1) return "R3";
    if (op == 2) return "R4";
    if (op == 3) return "R5";
    if (op <= 6) return "R6";
    if (op <= 9) return "R7";
    return "R8/R9";
  endfunction

  function automatic int reverse10(int v);
    int r = 0;
    for (int i = 0; i < 10; i++) begin
      r = r * 2 + (v % 2);
      v = v / 2;
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle: drive, compare outputs against the model, advance the model
  task automatic step(int op, int rf, int imm);
    int simm, ofs, e_addr, e_en, n_ar;
    @(negedge clk_i);
    op_i  = op[3:0];
    rf_i  = rf[15:0];
    imm_i = imm[9:0];
    simm  = (imm >= 512) ? imm - 1024 : imm;
    e_addr = m_ar;
    e_en   = 1;
    n_ar   = m_ar;
    case (op)
      1: e_addr = (rf + simm) & 16'hFFFF;
      2: e_addr = (m_ar + rf) & 16'hFFFF;
      3: begin e_en = 0; n_ar = rf; end
      4, 5, 6: begin
        ofs = simm * (1 << (op - 4));
        e_addr = (m_ar + ofs) & 16'hFFFF;
      end
      7, 8, 9: begin
        ofs = simm * (1 << (op - 7));
        e_addr = (m_ar + ofs) & 16'hFFFF;
        n_ar = e_addr;
      end
      10: e_addr = (m_ar & 16'hFC00) + reverse10(m_cnt);
      default: e_en = 0;
    endcase
    #1;
    tests++;
    if (addr_o != e_addr[15:0] || mem_en_o != e_en[0] || ar_o != m_ar[15:0]) begin
      fails++;
      $display("FAIL %s: op %0d actual addr 0x%0h en %0d ar 0x%0h expected addr 0x%0h en %0d ar 0x%0h",
               req_of(op), op, addr_o, mem_en_o, ar_o, e_addr, e_en, m_ar);
    end
    if (op == 10 && addr_o[15:10] == m_ar[15:10]) seen[addr_o[9:0]] = 1'b1;
    if (op == 3) m_cnt = 0;
    else if (op == 10) m_cnt = (m_cnt + 1) % 1024;
    m_ar = n_ar;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cov;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: reset state
    check("R1", ar_o, 0);
    check("R1", mem_en_o, 0);
    step(10, 0, 0);              // R1: first walk address low bits 0
    step(10, 0, 0);              // R9: counter advanced to 1 -> 0x200
    // R5 load, R2 idle and unused codes
    step(3, 16'h1234, 0);
    step(0, 16'hFFFF, 10'h3FF);
    step(13, 16'hAAAA, 10'h155);
    step(15, 16'h5555, 10'h0AA);
    // R3 with negative immediates and wrap (R10)
    step(1, 0, 10'h3FF);
    step(1, 16'h8000, 10'h1FF);
    step(1, 16'h0010, 10'h200);
    // R4 with wrap (R10)
    step(2, 16'hF000, 0);
    step(2, 16'h0001, 0);
    // R6 scaled offsets
    for (int op = 4; op <= 6; op++) begin
      step(op, 0, 10'h200);
      step(op, 0, 10'h155);
      step(op, 0, 10'h3FE);
    end
    // R7 post-modify, forward, backward and wrapping (R10)
    step(3, 16'hFFF0, 0);
    step(7, 0, 10'h020);
    step(8, 0, 10'h3F0);
    step(9, 0, 10'h07F);
    step(9, 0, 10'h200);
    step(7, 0, 10'h001);
    // R9: interrupted walk continues; load clears the counter
    step(3, 16'h4C00, 0);
    for (int i = 0; i < 5; i++) step(10, 0, 0);
    step(0, 0, 0);
    step(4, 0, 10'h004);
    for (int i = 0; i < 3; i++) step(10, 0, 0);
    step(3, 16'h4C00, 0);
    // R9: full walk covers the buffer, then wraps to the base
    foreach (seen[i]) seen[i] = 1'b0;
    for (int i = 0; i < 1024; i++) step(10, 16'h1111, 10'h2AB);
    cov = 0;
    foreach (seen[i]) if (seen[i]) cov++;
    check("R9", cov, 1024);
    step(10, 0, 0);
    check("R9", addr_o, 16'h4C00);
    // R8: unaligned AR keeps only its upper bits
    step(3, 16'h83FF, 0);
    step(10, 0, 0);
    step(10, 0, 0);
    // mixed traffic over every code
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
           int'($urandom_range(0, 1023)));
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule